// File: doc/BRIEF.md
# Prescaled Sleep Timer with Compares

This block is a free-running system timer for timekeeping and for scheduling wake-ups. The clock oscillators stay outside the block. Two slow sources reach it as one-cycle tick enables: a 1 kHz reference tick and a 32 kHz crystal tick. A select bit picks which source is counted.

The chosen tick passes through a power-of-two prescaler whose exponent is programmable. Every 2^N selected ticks the prescaler advances the timer counter by one. Three sticky event flags are kept:

- two compare-match flags, one per compare register;
- one wrap flag, set when the counter rolls over.

Two mask registers route any mix of these flags to an interrupt output and to a wake-up output.

Software programs the block through a simple write port. While the debugger holds the CPU halted, the prescaler and the counter freeze. No configuration bit is involved in this. If the selected source stops ticking, the timer stops with it and can raise no events.

Top module: `sleep_tick_timer`

## Requirements
- R1: After reset the count is 0, all three flags are 0, `irq_o` and `wake_o` are 0, the 1 kHz source is selected and the exponent is 0.
- R2: Control register (address 0) bit 0 selects the source: 0 selects `tick_slow` and 1 selects `tick_xtal`. Ticks on the unselected input have no effect.
- R3: Control bits [7:4] hold the exponent N. The counter increments by exactly one after every 2^N selected ticks, and it never changes by any other amount.
- R4: A control write that changes the select bit or the exponent empties the prescaler, so the next increment needs a full 2^N new ticks. A tick arriving in the cycle of that write is not counted.
- R5: While `dbg_halt` is 1, selected ticks are ignored and both the count and the prescaler hold.
- R6: Flag bit 0 sets on the increment where the count becomes equal to compare A (address 1). Flag bit 1 does the same for compare B (address 2).
- R7: Flag bit 2 sets on the increment where the count rolls over from all ones to 0.
- R8: Flags stay set until cleared. Writing 1 to a bit of address 3 clears that flag, and writing 0 to a bit leaves that flag unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq_o` is the OR of the flags ANDed with the interrupt mask (address 4, bits [2:0]). `wake_o` is the OR of the flags ANDed with the wake mask (address 5, bits [2:0]).
- R10: With no tick on the selected input, the count and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_slow | input | 1 | 1 kHz reference tick enable |
| tick_xtal | input | 1 | 32 kHz crystal tick enable |
| dbg_halt | input | 1 | Debugger halts CPU; freezes the timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| count_o | output | CNT_W | Current timer value |
| flags_o | output | 3 | Sticky flags: {wrap, compare B, compare A} |
| irq_o | output | 1 | Masked interrupt request |
| wake_o | output | 1 | Masked wake-up request |

## Verification
The bench builds the block with a 10-bit counter and the default 15-bit prescaler. With the narrow counter, a rollover takes only about a thousand ticks at exponent 0, so the wrap flag and the compare matches near all ones are reached many times. Random control writes keep the exponent between 0 and 3, so the prescaler restarts and full periods occur often. The prescaler counter keeps its full width, so its limit arithmetic is exercised at the default size.

// File: rtl/slp_pkg.sv
package slp_pkg;
   localparam int ADDR_W = 3;
   localparam int NFLAG  = 3;
   localparam int NCMP   = 2;
   localparam int SEL_BIT = 0;
   localparam int EXP_LSB = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL  = 3'd0,
      RA_CMPA  = 3'd1,
      RA_CMPB  = 3'd2,
      RA_CLEAR = 3'd3,
      RA_IRQM  = 3'd4,
      RA_WAKEM = 3'd5
   } reg_addr_e;

   localparam int FL_WRAP = 2;
endpackage

// File: rtl/slp_regs.sv
module slp_regs
   import slp_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int EXP_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   output logic                          sel_o,
   output logic [EXP_W-1:0]              exp_o,
   output logic [NCMP-1:0][CNT_W-1:0]    cmp_o,
   output logic [NFLAG-1:0]              clr_o,
   output logic [NFLAG-1:0]              irqm_o,
   output logic [NFLAG-1:0]              wakem_o,
   output logic                          restart_o
);
   logic                       sel_q;
   logic [EXP_W-1:0]           exp_q;
   logic [NCMP-1:0][CNT_W-1:0] cmp_q;
   logic [NFLAG-1:0]           irqm_q, wakem_q;
   logic                       wr_ctrl;

   assign wr_ctrl   = wr_en && (wr_addr == RA_CTRL);
   assign restart_o = wr_ctrl && ((wr_data[SEL_BIT] != sel_q) ||
                                  (wr_data[EXP_LSB +: EXP_W] != exp_q));
   assign clr_o     = (wr_en && (wr_addr == RA_CLEAR)) ? wr_data[NFLAG-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         exp_q   <= '0;
         cmp_q   <= '0;
         irqm_q  <= '0;
         wakem_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_CTRL: begin
               sel_q <= wr_data[SEL_BIT];
               exp_q <= wr_data[EXP_LSB +: EXP_W];
            end
            RA_CMPA:  cmp_q[0] <= wr_data;
            RA_CMPB:  cmp_q[1] <= wr_data;
            RA_IRQM:  irqm_q   <= wr_data[NFLAG-1:0];
            RA_WAKEM: wakem_q  <= wr_data[NFLAG-1:0];
            default: ;
         endcase
      end
   end

   assign sel_o   = sel_q;
   assign exp_o   = exp_q;
   assign cmp_o   = cmp_q;
   assign irqm_o  = irqm_q;
   assign wakem_o = wakem_q;

   a_r2_sel_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (sel_q == $past(wr_data[SEL_BIT])));
endmodule

// File: rtl/slp_prescaler.sv
module slp_prescaler #(
   parameter int PRE_W = 15,
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             restart_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             tick_o
);
   localparam int MAX_EXP = (1 << EXP_W) - 1;

   generate
      if (PRE_W < MAX_EXP) begin : g_bad_width
         $error("slp_prescaler: PRE_W too small for the exponent range");
      end
   endgenerate

   logic [PRE_W:0]   one_sh;
   logic [PRE_W-1:0] lim;
   logic [PRE_W-1:0] pre_q;
   logic             at_lim;

   assign one_sh = (PRE_W+1)'(1) << exp_i;
   assign lim    = PRE_W'(one_sh - (PRE_W+1)'(1));
   assign at_lim = (pre_q == lim);
   assign tick_o = adv_i && !restart_i && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (restart_i)
         pre_q <= '0;
      else if (adv_i)
         pre_q <= at_lim ? '0 : pre_q + 1'b1;
   end

   a_r4_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (pre_q == '0));
   a_r3_within_period: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= lim);
   a_r5_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !restart_i) |=> $stable(pre_q));
endmodule

// File: rtl/slp_event_flag.sv
module slp_event_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
endmodule

// File: rtl/sleep_tick_timer.sv
module sleep_tick_timer
   import slp_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int PRE_W = 15,
   parameter int EXP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_slow,
   input  logic              tick_xtal,
   input  logic              dbg_halt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [NFLAG-1:0]  flags_o,
   output logic              irq_o,
   output logic              wake_o
);
   generate
      if (CNT_W < EXP_LSB + EXP_W) begin : g_bad_cnt
         $error("sleep_tick_timer: CNT_W cannot hold the control fields");
      end
   endgenerate

   logic                       sel;
   logic [EXP_W-1:0]           expn;
   logic [NCMP-1:0][CNT_W-1:0] cmp;
   logic [NFLAG-1:0]           clr, irqm, wakem, set_ev, flags;
   logic                       restart, src_tick, tmr_tick;
   logic [CNT_W-1:0]           count_q, count_nx;

   slp_regs #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sel_o(sel), .exp_o(expn), .cmp_o(cmp),
      .clr_o(clr), .irqm_o(irqm), .wakem_o(wakem), .restart_o(restart)
   );

   assign src_tick = sel ? tick_xtal : tick_slow;

   slp_prescaler #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .adv_i(src_tick && !dbg_halt),
      .restart_i(restart), .exp_i(expn), .tick_o(tmr_tick)
   );

   assign count_nx = count_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (tmr_tick)
         count_q <= count_nx;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NCMP; gi++) begin : g_cmp
         assign set_ev[gi] = tmr_tick && (count_nx == cmp[gi]);
      end
   endgenerate
   assign set_ev[FL_WRAP] = tmr_tick && (count_q == '1);

   generate
      for (gi = 0; gi < NFLAG; gi++) begin : g_flag
         slp_event_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(set_ev[gi]),
            .clr_i(clr[gi]), .flag_o(flags[gi])
         );
      end
   endgenerate

   assign count_o = count_q;
   assign flags_o = flags;
   assign irq_o   = |(flags & irqm);
   assign wake_o  = |(flags & wakem);

   a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q != $past(count_q)) |-> (count_q == $past(count_q) + 1'b1));
   a_r5_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_halt |=> $stable(count_q));
   a_r7_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_tick && count_q == '1) |=> (flags_o[FL_WRAP] && count_q == '0));
   a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_slow && !tick_xtal) |=> $stable(count_q));
endmodule

// File: tb/sim_sleep_tick_timer.sv
`timescale 1ns/1ps
module sim_sleep_tick_timer;
   localparam int CNT_W = 10;
   localparam int PRE_W = 15;
   localparam int EXP_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_slow = 0, tick_xtal = 0, dbg_halt = 0, wr_en = 0;
   logic [2:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [CNT_W-1:0] count_o;
   logic [2:0]       flags_o;
   logic             irq_o, wake_o;

   int checks = 0;
   int errors = 0;

   // model state
   logic             m_sel;
   logic [3:0]       m_exp;
   int unsigned      m_pre;
   logic [CNT_W-1:0] m_cnt, m_cmpa, m_cmpb;
   logic [2:0]       m_flags, m_irqm, m_wakem;

   always #2.5 clk = ~clk;

   sleep_tick_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .EXP_W(EXP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_xtal(tick_xtal),
      .dbg_halt(dbg_halt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .count_o(count_o), .flags_o(flags_o), .irq_o(irq_o), .wake_o(wake_o)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [CNT_W-1:0] ctrl_word(input logic s, input logic [3:0] e);
      ctrl_word = CNT_W'({e, 3'b000, s});
   endfunction

   function automatic logic mask_or(input logic [2:0] f, input logic [2:0] m);
      mask_or = |(f & m);
   endfunction

   // drive one cycle, advance model, check after the edge
   task automatic step(input string tag, input logic ts, input logic tx, input logic h,
                       input logic we, input logic [2:0] a, input logic [CNT_W-1:0] d);
      logic chg, tsel, tt;
      logic [CNT_W-1:0] nc;
      logic [2:0] set, clr;
      tick_slow = ts; tick_xtal = tx; dbg_halt = h;
      wr_en = we; wr_addr = a; wr_data = d;
      tsel = m_sel ? tx : ts;
      chg = we && a == 3'd0 && (d[0] != m_sel || d[7:4] != m_exp);
      tt = 1'b0;
      if (chg) m_pre = 0;
      else if (tsel && !h) begin
         if (m_pre == (32'd1 << m_exp) - 1) begin tt = 1'b1; m_pre = 0; end
         else m_pre = m_pre + 1;
      end
      nc = tt ? m_cnt + 1'b1 : m_cnt;
      set[0] = tt && nc == m_cmpa;
      set[1] = tt && nc == m_cmpb;
      set[2] = tt && m_cnt == '1;
      clr = (we && a == 3'd3) ? d[2:0] : 3'b000;
      m_flags = (m_flags & ~clr) | set;
      m_cnt = nc;
      if (we) case (a)
         3'd0: begin m_sel = d[0]; m_exp = d[7:4]; end
         3'd1: m_cmpa = d;
         3'd2: m_cmpb = d;
         3'd4: m_irqm = d[2:0];
         3'd5: m_wakem = d[2:0];
         default: ;
      endcase
      @(negedge clk);
      chk(tag, 32'(count_o), 32'(m_cnt));
      chk("flags R6 R7 R8", 32'(flags_o), 32'(m_flags));
      chk("irq R9", 32'(irq_o), 32'(mask_or(m_flags, m_irqm)));
      chk("wake R9", 32'(wake_o), 32'(mask_or(m_flags, m_wakem)));
   endtask

   task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
      step("R3", 0, 0, 0, 1, a, d);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic [CNT_W-1:0] snap;
      seed = $urandom(32'h5EED);
      m_sel = 0; m_exp = 0; m_pre = 0; m_cnt = 0; m_cmpa = 0; m_cmpb = 0;
      m_flags = 0; m_irqm = 0; m_wakem = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", 32'(count_o), 0);
      chk("R1 flags", 32'(flags_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 wake", 32'(wake_o), 0);
      // R1: slow source selected by default, exponent 0
      step("R1", 1, 0, 0, 0, 0, 0);
      chk("R1 default source", 32'(count_o), 1);

      // R2: select crystal, slow ticks ignored
      wr(3'd0, ctrl_word(1'b1, 4'd0));
      snap = count_o;
      for (int i = 0; i < 5; i++) step("R2", 1, 0, 0, 0, 0, 0);
      chk("R2 unselected ignored", 32'(count_o), 32'(snap));
      step("R2", 0, 1, 0, 0, 0, 0);
      chk("R2 crystal counts", 32'(count_o), 32'(snap + 1'b1));

      // R5: halt freezes
      snap = count_o;
      for (int i = 0; i < 6; i++) step("R5", 1, 1, 1, 0, 0, 0);
      chk("R5 halt freeze", 32'(count_o), 32'(snap));

      // R10: no ticks, nothing moves
      for (int i = 0; i < 4; i++) step("R10", 0, 0, 0, 0, 0, 0);
      chk("R10 idle hold", 32'(count_o), 32'(snap));

      // R3 / R4: exponent 2, three ticks, then change to exponent 1
      wr(3'd0, ctrl_word(1'b0, 4'd2));
      snap = count_o;
      for (int i = 0; i < 3; i++) step("R3", 1, 0, 0, 0, 0, 0);
      chk("R3 partial period", 32'(count_o), 32'(snap));
      step("R4", 1, 0, 0, 0, 0, 0);
      chk("R3 full period", 32'(count_o), 32'(snap + 1'b1));
      for (int i = 0; i < 3; i++) step("R4", 1, 0, 0, 0, 0, 0);
      step("R4", 1, 0, 0, 1, 3'd0, ctrl_word(1'b0, 4'd1));
      chk("R4 tick on write dropped", 32'(count_o), 32'(snap + 1'b1));
      step("R4", 1, 0, 0, 0, 0, 0);
      chk("R4 prescaler emptied", 32'(count_o), 32'(snap + 1'b1));
      step("R4", 1, 0, 0, 0, 0, 0);
      chk("R4 new period", 32'(count_o), 32'(snap + 2'd2));

      // R6 R7 R9: compare and wrap at exponent 0, with masks
      wr(3'd0, ctrl_word(1'b0, 4'd0));
      wr(3'd1, CNT_W'(700));
      wr(3'd2, '1);
      wr(3'd4, CNT_W'(3'b101));
      wr(3'd5, CNT_W'(3'b010));
      wr(3'd3, CNT_W'(3'b111));
      for (int i = 0; i < 1100; i++) step("R7", 1, 0, 0, 0, 0, 0);
      chk("R6 compare A hit", 32'(flags_o[0]), 1);
      chk("R6 compare B hit", 32'(flags_o[1]), 1);
      chk("R7 wrap hit", 32'(flags_o[2]), 1);
      // R8: clear of zeros leaves flags, clear of one bit clears it
      step("R8", 0, 0, 0, 1, 3'd3, '0);
      chk("R8 zero clear", 32'(flags_o), 32'(3'b111));
      step("R8", 0, 0, 0, 1, 3'd3, CNT_W'(3'b001));
      chk("R8 single clear", 32'(flags_o), 32'(3'b110));

      // random phase
      for (int i = 0; i < 8000; i++) begin
         logic we;
         logic [2:0] a;
         logic [CNT_W-1:0] d;
         we = ($urandom % 8) == 0;
         a = 3'($urandom % 8);
         d = CNT_W'($urandom);
         if (a == 3'd0) d = ctrl_word(1'($urandom), 4'($urandom % 4));
         step("R3", 1'($urandom), 1'($urandom), ($urandom % 16) == 0, we, a, d);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule